// File: doc/BRIEF.md
# Crossbar Slave Port Arbiter

This block decides which bus master owns one slave port of a multi-master crossbar. Up to eight masters each drive a request line, and a separate halt request competes for the same port. The block returns a one-hot master grant, a halt grant and a port enable. A transfer of any length is modelled as a request that stays high. The grant stays with its owner until that request drops.

A single 32-bit control word sets the behaviour. It selects fixed-priority or round-robin arbitration and gives each master a high-priority enable. It sets where the halt request ranks at first arbitration, and it chooses what the port does when idle: park on a chosen master, park on the most recent owner, or shut down into a low-power idle state. A lock bit in the word freezes the whole register until the next hardware reset. The word is written through a one-cycle write strobe and is always visible on a read bus.

Top module: `xbar_slave_arb`

## Requirements
- R1: During and right after reset, the control word reads 0. The port is parked on master 0 (grant 0x01), port enable is 1 and the halt grant is 0.
- R2: Control word layout in LSB-0 numbering. Lock is bit 31 and halt-low-priority is bit 30. The high-priority enable of master m is bit 16+m. The arbitration mode is bits 9:8, park control is bits 5:4 and the park master index is bits 2:0. Every other bit reads 0, so the writable mask is 0xC0FF0337.
- R3: While the lock is 0, every write takes effect, including repeated writes with lock 0. A write with bit 31 set takes effect in full. After that, every write is ignored until rst_ni is asserted.
- R4: Mode 0 is fixed priority: the lowest-index requester wins. When the port is parked on a different master, the winner's grant appears one clock after its request.
- R5: A requester whose high-priority enable is 1 beats every requester whose enable is 0.
- R6: Mode 1 is round-robin. The search starts at the master after the last granted one and wraps around after master N-1.
- R7: With halt-low-priority 0, a halt request beats every master at first arbitration. With it set to 1, the halt request wins only when no master requests.
- R8: Once the halt grant is given, it stays until halt_req_i drops, whatever the halt-low-priority bit and the master requests are.
- R9: A granted master keeps the grant while its request stays high, even against a pending halt request. Re-arbitration takes effect at the edge after the request drops.
- R10: When no request is pending, park control 0 or 3 parks on the master in the park index field. Park control 1 parks on the last granted master. A parked master that requests keeps the grant without a gap.
- R11: Park control 2 drives grant to 0 and port enable to 0 when idle. A request then raises port enable at the first edge and the grant at the second edge.
- R12: At most one of the grant bits and the halt grant is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MASTERS | Master request lines |
| halt_req_i | input | 1 | Halt request |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| grant_o | output | NUM_MASTERS | One-hot master grant |
| halt_grant_o | output | 1 | Halt owns the port |
| port_en_o | output | 1 | Port active; low only in low-power idle |

## Verification
The bench goes after these cases:

- **Parked master requesting while others also request.** A design that re-arbitrates here would hand the port away from a master that already holds it.
- **A halt request arriving while a master is busy, and a master arriving while the halt is busy.** A design that gets either wrong would cut a transfer short.
- **The halt-low-priority bit changing while the halt owns the port.** A design that applies the bit after the first win would drop the halt grant.
- **The round-robin wrap-around.** A wrong wrap skips or repeats a master.
- **The two-edge wake-up from low-power idle.** A wrong design grants one cycle early or late.
- **Lock boundary.** A write after the lock must leave both the read data and the parked master unchanged until reset.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned LOCK_BIT = 31;
  localparam int unsigned HLP_BIT  = 30;
  localparam int unsigned HPE_LSB  = 16;
  localparam int unsigned MODE_LSB = 8;
  localparam int unsigned PCTL_LSB = 4;
  localparam int unsigned PIDX_LSB = 0;
  localparam int unsigned MAX_MST  = 8;

  typedef enum logic [1:0] {
    PARK_FIXED = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_LP    = 2'd2,
    PARK_ALT   = 2'd3
  } park_ctl_e;

  typedef enum logic [2:0] {
    ST_LP   = 3'd0,
    ST_WAKE = 3'd1,
    ST_PARK = 3'd2,
    ST_MST  = 3'd3,
    ST_HALT = 3'd4
  } port_st_e;

  typedef struct packed {
    logic               lock;
    logic               hlp;
    logic [MAX_MST-1:0] hpe;
    logic [1:0]         mode;
    park_ctl_e          pctl;
    logic [2:0]         pidx;
  } cfg_t;
endpackage

// File: rtl/xbar_cfg_reg.sv
module xbar_cfg_reg
  import xbar_arb_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [MAX_MST-1:0] HPE_MASK = MAX_MST'((1 << NUM_MASTERS) - 1);

  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i && !cfg_q.lock) begin
      cfg_q.lock <= wdata_i[LOCK_BIT];
      cfg_q.hlp  <= wdata_i[HLP_BIT];
      cfg_q.hpe  <= wdata_i[HPE_LSB +: MAX_MST] & HPE_MASK;
      cfg_q.mode <= wdata_i[MODE_LSB +: 2];
      cfg_q.pctl <= park_ctl_e'(wdata_i[PCTL_LSB +: 2]);
      cfg_q.pidx <= wdata_i[PIDX_LSB +: 3];
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[LOCK_BIT]           = cfg_q.lock;
    rdata_o[HLP_BIT]            = cfg_q.hlp;
    rdata_o[HPE_LSB +: MAX_MST] = cfg_q.hpe;
    rdata_o[MODE_LSB +: 2]      = cfg_q.mode;
    rdata_o[PCTL_LSB +: 2]      = cfg_q.pctl;
    rdata_o[PIDX_LSB +: 3]      = cfg_q.pidx;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/xbar_pick.sv
module xbar_pick #(
  parameter int unsigned NUM_MASTERS = 8,
  parameter int unsigned IDX_W       = 3
) (
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic [NUM_MASTERS-1:0] hpe_i,
  input  logic                   rr_i,
  input  logic [IDX_W-1:0]       last_i,
  output logic                   valid_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [NUM_MASTERS-1:0] hot;
  logic [NUM_MASTERS-1:0] cand;
  int unsigned            start;
  int unsigned            pos;

  always_comb begin
    hot  = req_i & hpe_i;
    cand = (|hot) ? hot : req_i;
    // round-robin begins one past the previous owner
    start = 0;
    if (rr_i && (int'(last_i) < int'(NUM_MASTERS) - 1)) start = int'(last_i) + 1;
    valid_o = 1'b0;
    idx_o   = '0;
    pos     = 0;
    for (int unsigned k = 0; k < NUM_MASTERS; k++) begin
      pos = start + k;
      if (pos >= NUM_MASTERS) pos = pos - NUM_MASTERS;
      if (!valid_o && cand[pos]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(pos);
      end
    end
  end
endmodule

// File: rtl/xbar_port_fsm.sv
module xbar_port_fsm
  import xbar_arb_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 8,
  parameter int unsigned IDX_W       = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic                   halt_req_i,
  input  cfg_t                   cfg_i,
  input  logic                   pick_valid_i,
  input  logic [IDX_W-1:0]       pick_idx_i,
  output port_st_e               st_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [IDX_W-1:0]       last_o
);
  port_st_e         st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d, park_idx;
  logic             go, halt_first;

  // out-of-range park index falls back to master 0
  assign park_idx   = (32'(cfg_i.pidx) < NUM_MASTERS) ? IDX_W'(cfg_i.pidx) : '0;
  assign halt_first = halt_req_i && (!cfg_i.hlp || !(|req_i));

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    last_d = last_q;
    go     = 1'b0;
    unique case (st_q)
      ST_HALT: go = !halt_req_i;
      ST_MST:  go = !req_i[idx_q];
      ST_PARK: begin
        if (req_i[idx_q]) begin
          st_d   = ST_MST;
          last_d = idx_q;
        end else begin
          go = 1'b1;
        end
      end
      ST_LP: begin
        if ((|req_i) || halt_req_i) st_d = ST_WAKE;
        else go = 1'b1;
      end
      ST_WAKE: go = 1'b1;
      default: go = 1'b1;
    endcase
    if (go) begin
      if (halt_first) begin
        st_d = ST_HALT;
      end else if (pick_valid_i) begin
        st_d   = ST_MST;
        idx_d  = pick_idx_i;
        last_d = pick_idx_i;
      end else begin
        unique case (cfg_i.pctl)
          PARK_LAST: begin
            st_d  = ST_PARK;
            idx_d = last_q;
          end
          PARK_LP: st_d = ST_LP;
          default: begin
            st_d  = ST_PARK;
            idx_d = park_idx;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PARK;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  assign st_o   = st_q;
  assign idx_o  = idx_q;
  assign last_o = last_q;
endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb
  import xbar_arb_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic                   halt_req_i,
  input  logic                   reg_we_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [REG_W-1:0]       reg_rdata_o,
  output logic [NUM_MASTERS-1:0] grant_o,
  output logic                   halt_grant_o,
  output logic                   port_en_o
);
  localparam int unsigned IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  cfg_t             cfg;
  logic             pick_valid;
  logic [IDX_W-1:0] pick_idx, own_idx, last_idx;
  port_st_e         st;

  xbar_cfg_reg #(.NUM_MASTERS(NUM_MASTERS)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (reg_rdata_o)
  );

  xbar_pick #(.NUM_MASTERS(NUM_MASTERS), .IDX_W(IDX_W)) u_pick (
    .req_i   (req_i),
    .hpe_i   (cfg.hpe[NUM_MASTERS-1:0]),
    .rr_i    (cfg.mode == 2'd1),
    .last_i  (last_idx),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  xbar_port_fsm #(.NUM_MASTERS(NUM_MASTERS), .IDX_W(IDX_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .halt_req_i   (halt_req_i),
    .cfg_i        (cfg),
    .pick_valid_i (pick_valid),
    .pick_idx_i   (pick_idx),
    .st_o         (st),
    .idx_o        (own_idx),
    .last_o       (last_idx)
  );

  assign grant_o      = (st == ST_PARK || st == ST_MST) ?
                        (NUM_MASTERS'(1) << own_idx) : '0;
  assign halt_grant_o = (st == ST_HALT);
  assign port_en_o    = (st != ST_LP);
endmodule

// File: rtl/xbar_slave_arb_chk.sv
module xbar_slave_arb_chk #(
  parameter int unsigned NUM_MASTERS = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_MASTERS-1:0] req_i,
  input logic                   halt_req_i,
  input logic                   reg_we_i,
  input logic [31:0]            reg_rdata_o,
  input logic [NUM_MASTERS-1:0] grant_o,
  input logic                   halt_grant_o,
  input logic                   port_en_o
);
  // R12
  single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, halt_grant_o}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_o |-> (grant_o == '0 && !halt_grant_o));

  // R11
  wake_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_en_o && ((|req_i) || halt_req_i)) |=> (port_en_o && grant_o == '0 && !halt_grant_o));

  // R8
  halt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_grant_o && halt_req_i) |=> halt_grant_o);

  // R9
  owner_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & req_i) != '0) |=> (grant_o == $past(grant_o)));

  // R3
  lock_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31] && reg_we_i) |=> $stable(reg_rdata_o));
endmodule

bind xbar_slave_arb xbar_slave_arb_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .halt_req_i   (halt_req_i),
  .reg_we_i     (reg_we_i),
  .reg_rdata_o  (reg_rdata_o),
  .grant_o      (grant_o),
  .halt_grant_o (halt_grant_o),
  .port_en_o    (port_en_o)
);

// File: tb/xbar_slave_arb_bench.sv
module xbar_slave_arb_bench;
  localparam int unsigned NM = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NM-1:0] req = '0;
  logic          halt = 1'b0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NM-1:0] grant;
  logic          hgnt;
  logic          pen;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xbar_slave_arb #(.NUM_MASTERS(NM)) u_xbar_slave_arb (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .req_i        (req),
    .halt_req_i   (halt),
    .reg_we_i     (we),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .grant_o      (grant),
    .halt_grant_o (hgnt),
    .port_en_o    (pen)
  );

  // {cfg[31:0], req[7:0], halt, exp_grant[7:0], exp_halt_grant}; park on m7, ctl 0
  localparam logic [49:0] VEC [8] = '{
    {32'h0000_0007, 8'h06, 1'b0, 8'h02, 1'b0},  // R4 lowest index
    {32'h0000_0007, 8'h60, 1'b1, 8'h00, 1'b1},  // R7 halt first
    {32'h4000_0007, 8'h60, 1'b1, 8'h20, 1'b0},  // R7 halt last
    {32'h4000_0007, 8'h00, 1'b1, 8'h00, 1'b1},  // R7 halt alone
    {32'h0010_0007, 8'h13, 1'b0, 8'h10, 1'b0},  // R5 enabled wins
    {32'h0010_0007, 8'h03, 1'b0, 8'h01, 1'b0},  // R5 enable idle
    {32'h0000_0007, 8'h81, 1'b0, 8'h80, 1'b0},  // R10 parked keeps
    {32'h0040_0007, 8'h48, 1'b1, 8'h00, 1'b1}   // R7 over enabled
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    we = 1'b1;
    wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    check("R1 rdata", rdata, 32'h0);
    check("R1 grant", {24'h0, grant}, 32'h01);
    check("R1 port_en/halt", {30'h0, pen, hgnt}, 32'h2);

    // R2 writable mask; ctl 3 parks on index field (R10)
    wr(32'h3FFF_FFFF);
    check("R2 mask", rdata, 32'h00FF_0337);
    tick(1);
    check("R10 alt park", {24'h0, grant}, 32'h80);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][49:18]);
      req = '0;
      halt = 1'b0;
      tick(2);
      check("R10 park idx", {24'h0, grant}, 32'h80);
      req  = VEC[i][17:10];
      halt = VEC[i][9];
      tick(1);
      check("vector grant", {24'h0, grant}, {24'h0, VEC[i][8:1]});
      check("vector halt grant", {31'h0, hgnt}, {31'h0, VEC[i][0]});
      req = '0;
      halt = 1'b0;
    end

    // R9 hold against other master and pending halt
    wr(32'h0);
    tick(2);
    req = 8'h02;
    tick(1);
    check("R4 grant m1", {24'h0, grant}, 32'h02);
    req = 8'h03;
    halt = 1'b1;
    tick(3);
    check("R9 hold", {24'h0, grant}, 32'h02);
    req = 8'h01;
    tick(1);
    check("R9 rearb to halt", {31'h0, hgnt}, 32'h1);
    wr(32'h4000_0000);
    tick(1);
    check("R8 halt kept", {31'h0, hgnt}, 32'h1);
    halt = 1'b0;
    tick(1);
    check("R8 release", {24'h0, grant}, 32'h01);
    req = '0;

    // R6 round robin with park on last
    wr(32'h0000_0110);
    tick(2);
    check("R10 park last", {24'h0, grant}, 32'h01);
    req = 8'h94;
    tick(1);
    check("R6 step m2", {24'h0, grant}, 32'h04);
    req = 8'h90;
    tick(1);
    check("R6 step m4", {24'h0, grant}, 32'h10);
    req = 8'h84;
    tick(1);
    check("R6 step m7", {24'h0, grant}, 32'h80);
    req = 8'h14;
    tick(1);
    check("R6 wrap m2", {24'h0, grant}, 32'h04);
    req = '0;
    tick(2);
    check("R10 park last m2", {24'h0, grant}, 32'h04);

    // R11 low-power idle
    wr(32'h0000_0020);
    tick(1);
    check("R11 idle", {23'h0, pen, grant}, 32'h0);
    req = 8'h08;
    tick(1);
    check("R11 wake", {23'h0, pen, grant}, 32'h100);
    tick(1);
    check("R11 grant", {23'h0, pen, grant}, 32'h108);
    req = '0;
    tick(2);
    check("R11 back idle", {31'h0, pen}, 32'h0);

    // R3 lock
    wr(32'h0000_0003);
    check("R3 write 1", rdata, 32'h3);
    wr(32'h0000_0005);
    check("R3 write 2", rdata, 32'h5);
    wr(32'h8000_0004);
    check("R3 lock set", rdata, 32'h8000_0004);
    tick(1);
    check("R3 park m4", {24'h0, grant}, 32'h10);
    wr(32'h0000_0001);
    tick(2);
    check("R3 ignored rdata", rdata, 32'h8000_0004);
    check("R3 ignored park", {24'h0, grant}, 32'h10);
    rst_ni = 1'b0;
    tick(1);
    rst_ni = 1'b1;
    check("R3 reset clears", rdata, 32'h0);
    wr(32'h0000_0005);
    check("R3 writable again", rdata, 32'h5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule